// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous link: a serial data output, a serial data input and a shift clock shared by both directions. The host side looks like a small register file. A strobe loads the transmit buffer. The receive buffer is read combinationally and released with a read strobe. Level inputs select the options. The shift clock comes either from an internal programmable divider, with the unit as clock master, or from an external clock input, with the unit as clock slave.

In normal operation a transfer, and therefore a reception, is started only by a write to the transmit buffer. In continuous-receive mode a read of the receive buffer also starts the next transfer, with no dummy write. When no fresh transmit data is waiting, such a transfer shifts out all ones. When inversion is selected, the data is complemented as it enters the transmit buffer and again as it leaves the receive buffer. The line itself is never inverted.

The internal clock can be steered to either of two clock output pins. When this dual-pin routing is selected, the CTS/RTS flow control is switched off.

Top module: `sync_serial_unit`

## Requirements
- R1: After reset, txd_o, sclk_a_o, sclk_b_o and rts_no are high, and rx_done_o and overrun_o are low.
- R2: A frame is 8 bits, least significant bit first. txd_o changes on each falling shift-clock edge and rxd_i is sampled on each rising edge. The clock idles high. With the internal clock, each clock half-period lasts div_i+1 cycles of clk_i; div_i must be 3 or more. txd_o is high whenever no transfer is in progress.
- R3: Outside continuous-receive mode, no shift clock is produced and no byte is received until tx_wr_i loads the transmit buffer.
- R4: After the eighth bit the received byte is shown on rx_data_o and rx_done_o goes high. A one-cycle rx_rd_i pulse clears rx_done_o.
- R5: When a byte completes while rx_done_o is still high, overrun_o goes high and rx_data_o keeps the older byte. The next read clears both flags.
- R6: With cont_rx_i high, a read of the receive buffer starts a new transfer with no transmit write. If no new transmit data is waiting, that transfer sends 8'hFF.
- R7: With inv_i high, the transmit buffer stores the complement of tx_data_i, and rx_data_o shows the complement of the received byte.
- R8: With the internal clock, the shift clock appears on sclk_b_o when both dual_clk_i and clk_sel_i are high, and on sclk_a_o in every other case. The pin that is not selected stays high.
- R9: With int_clk_i low, the transfer is clocked by ext_clk_i. Both clock output pins stay high, whatever the values of dual_clk_i and clk_sel_i.
- R10: When hs_en_i is high and dual_clk_i is low, a transfer starts only while cts_ni is low, and rts_no is low while a transfer is armed or in progress. When hs_en_i is low or dual_clk_i is high, cts_ni is ignored and rts_no stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | DATA_W | Transmit buffer write data |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | DATA_W | Receive buffer contents |
| rx_done_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun flag |
| int_clk_i | input | 1 | 1: internal divider clock, 0: external clock |
| div_i | input | DIV_W | Half-period divider value |
| cont_rx_i | input | 1 | Continuous-receive mode |
| inv_i | input | 1 | Data inversion at buffer access |
| dual_clk_i | input | 1 | Enable routing of the clock to a chosen pin |
| clk_sel_i | input | 1 | Clock pin choice when routing is enabled (1 = pin B) |
| hs_en_i | input | 1 | Enable CTS/RTS flow control |
| ext_clk_i | input | 1 | External shift clock |
| sclk_a_o | output | 1 | Clock output pin A |
| sclk_b_o | output | 1 | Clock output pin B |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| cts_ni | input | 1 | Clear to send, active low |
| rts_no | output | 1 | Request to send, active low |

## Verification
The bench acts as the remote peer. It shifts a byte into rxd_i and collects txd_o on the opposite clock edges, so a design that reversed bit order or sampled on the wrong edge returns garbled bytes to the scoreboard. It idles with no write to catch a design that receives on its own. It also runs continuous mode through two back-to-back receptions, where a missing re-arm hangs the bench and a stale transmit byte replaces the expected all-ones. Further cases cover an unread byte followed by a second one, which a careless design would overwrite, and CTS held high, which must block the master. Finally, the dual-pin and external-clock cases count edges on both clock pins, so a clock leaking onto the wrong pin shows up in the counts.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic {
    WAIT_FALL = 1'b0,
    WAIT_RISE = 1'b1
  } ssu_phase_e;

  typedef enum logic [1:0] {
    PIN_NONE = 2'd0,
    PIN_A    = 2'd1,
    PIN_B    = 2'd2
  } ssu_pin_e;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  // all synchronized lines idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '1;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ssu_clkgen.sv
module ssu_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             int_clk_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_s_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             ext_prev_q;
  logic             tick;

  assign tick = run_i && int_clk_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i || !int_clk_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b1;
    else         ext_prev_q <= ext_s_i;
  end

  assign sclk_o = sclk_q;
  assign fall_o = int_clk_i ? (tick && sclk_q)  : (ext_prev_q && !ext_s_i);
  assign rise_o = int_clk_i ? (tick && !sclk_q) : (!ext_prev_q && ext_s_i);
endmodule

// File: rtl/ssu_shift.sv
module ssu_shift
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              rxd_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  ssu_phase_e        ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      txd_o   <= 1'b1;
      done_o  <= 1'b0;
      ph_q    <= WAIT_FALL;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o  <= 1'b1;
        tx_sh_q <= tx_byte_i;
        cnt_q   <= '0;
        ph_q    <= WAIT_FALL;
      end else if (busy_o) begin
        if (ph_q == WAIT_FALL && fall_i) begin
          txd_o   <= tx_sh_q[0];
          tx_sh_q <= tx_sh_q >> 1;
          ph_q    <= WAIT_RISE;
        end else if (ph_q == WAIT_RISE && rise_i) begin
          rx_sh_q <= {rxd_i, rx_sh_q[DATA_W-1:1]};
          ph_q    <= WAIT_FALL;
          if (cnt_q == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            txd_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign rx_byte_o = rx_sh_q;
endmodule

// File: rtl/ssu_ctrl.sv
module ssu_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic              inv_i,
  input  logic              cont_rx_i,
  input  logic              hs_act_i,
  input  logic              cts_s_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              start_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              overrun_o,
  output logic              rts_no
);
  logic [DATA_W-1:0] tx_buf_q, rx_buf_q;
  logic              tx_full_q, arm_q, rx_full_q, ovr_q;

  // flow control holds the start while CTS is deasserted
  assign start_o   = arm_q && !busy_i && !(hs_act_i && cts_s_i);
  assign tx_byte_o = tx_full_q ? tx_buf_q : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      if (start_o) begin
        arm_q     <= 1'b0;
        tx_full_q <= 1'b0;
      end
      if (tx_wr_i) begin
        tx_buf_q  <= inv_i ? ~tx_data_i : tx_data_i;
        tx_full_q <= 1'b1;
        arm_q     <= 1'b1;
      end else if (rx_rd_i && cont_rx_i) begin
        arm_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (rx_rd_i) begin
        rx_full_q <= 1'b0;
        ovr_q     <= 1'b0;
      end
      if (done_i) begin
        if (rx_full_q && !rx_rd_i) begin
          ovr_q <= 1'b1;
        end else begin
          rx_buf_q  <= rx_byte_i;
          rx_full_q <= 1'b1;
        end
      end
    end
  end

  assign rx_data_o = inv_i ? ~rx_buf_q : rx_buf_q;
  assign rx_done_o = rx_full_q;
  assign overrun_o = ovr_q;
  assign rts_no    = !(hs_act_i && (arm_q || busy_i));
endmodule

// File: rtl/ssu_pins.sv
module ssu_pins
  import ssu_pkg::*;
(
  input  logic int_clk_i,
  input  logic dual_i,
  input  logic sel_i,
  input  logic sclk_i,
  output logic sclk_a_o,
  output logic sclk_b_o
);
  ssu_pin_e route;

  always_comb begin
    route = PIN_NONE;
    if (int_clk_i) route = (dual_i && sel_i) ? PIN_B : PIN_A;
  end

  always_comb begin
    sclk_a_o = 1'b1;
    sclk_b_o = 1'b1;
    case (route)
      PIN_A:   sclk_a_o = sclk_i;
      PIN_B:   sclk_b_o = sclk_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              overrun_o,
  input  logic              int_clk_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cont_rx_i,
  input  logic              inv_i,
  input  logic              dual_clk_i,
  input  logic              clk_sel_i,
  input  logic              hs_en_i,
  input  logic              ext_clk_i,
  output logic              sclk_a_o,
  output logic              sclk_b_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              cts_ni,
  output logic              rts_no
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_d, sync_q;
  logic              ext_s, rxd_s, cts_s;
  logic              hs_act;
  logic              start, busy, done_p, fall_p, rise_p, sclk_int;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  assign sync_d = {cts_ni, rxd_i, ext_clk_i};
  assign {cts_s, rxd_s, ext_s} = sync_q;
  // dual-pin clock routing disables flow control
  assign hs_act = hs_en_i && !dual_clk_i;

  ssu_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  ssu_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy),
    .int_clk_i(int_clk_i),
    .div_i    (div_i),
    .ext_s_i  (ext_s),
    .sclk_o   (sclk_int),
    .fall_o   (fall_p),
    .rise_o   (rise_p)
  );

  ssu_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_byte_i(tx_byte),
    .fall_i   (fall_p),
    .rise_i   (rise_p),
    .rxd_i    (rxd_s),
    .busy_o   (busy),
    .txd_o    (txd_o),
    .done_o   (done_p),
    .rx_byte_o(rx_byte)
  );

  ssu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_wr_i  (tx_wr_i),
    .tx_data_i(tx_data_i),
    .rx_rd_i  (rx_rd_i),
    .inv_i    (inv_i),
    .cont_rx_i(cont_rx_i),
    .hs_act_i (hs_act),
    .cts_s_i  (cts_s),
    .busy_i   (busy),
    .done_i   (done_p),
    .rx_byte_i(rx_byte),
    .start_o  (start),
    .tx_byte_o(tx_byte),
    .rx_data_o(rx_data_o),
    .rx_done_o(rx_done_o),
    .overrun_o(overrun_o),
    .rts_no   (rts_no)
  );

  ssu_pins u_pins (
    .int_clk_i(int_clk_i),
    .dual_i   (dual_clk_i),
    .sel_i    (clk_sel_i),
    .sclk_i   (sclk_int),
    .sclk_a_o (sclk_a_o),
    .sclk_b_o (sclk_b_o)
  );
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              int_clk_i,
  input logic              dual_clk_i,
  input logic              clk_sel_i,
  input logic              hs_en_i,
  input logic              inv_i,
  input logic              rx_rd_i,
  input logic              rx_done_o,
  input logic              overrun_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              sclk_a_o,
  input logic              sclk_b_o,
  input logic              txd_o,
  input logic              busy,
  input logic              done_p,
  input logic              cts_s
);
  assert_txd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o);

  assert_rd_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !done_p) |=> !rx_done_o);

  assert_keep_old_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !rx_rd_i) |=>
      (rx_data_o == ((inv_i == $past(inv_i)) ? $past(rx_data_o) : ~$past(rx_data_o))));

  assert_overrun_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_done_o));

  assert_pin_a_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clk_i && dual_clk_i && clk_sel_i) |-> sclk_a_o);

  assert_pin_b_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clk_i && !(dual_clk_i && clk_sel_i)) |-> sclk_b_o);

  assert_ext_pins_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_clk_i |-> (sclk_a_o && sclk_b_o));

  assert_cts_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_i && !dual_clk_i && cts_s && !busy) |=> !busy);
endmodule

bind sync_serial_unit ssu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .int_clk_i (int_clk_i),
  .dual_clk_i(dual_clk_i),
  .clk_sel_i (clk_sel_i),
  .hs_en_i   (hs_en_i),
  .inv_i     (inv_i),
  .rx_rd_i   (rx_rd_i),
  .rx_done_o (rx_done_o),
  .overrun_o (overrun_o),
  .rx_data_o (rx_data_o),
  .sclk_a_o  (sclk_a_o),
  .sclk_b_o  (sclk_b_o),
  .txd_o     (txd_o),
  .busy      (busy),
  .done_p    (done_p),
  .cts_s     (cts_s)
);

// File: tb/sync_serial_unit_test.sv
module sync_serial_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_wr_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       rx_rd_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_done_o, overrun_o;
  logic       int_clk_i = 1'b1;
  logic [7:0] div_i = 8'd3;
  logic       cont_rx_i = 1'b0, inv_i = 1'b0, dual_clk_i = 1'b0, clk_sel_i = 1'b0;
  logic       hs_en_i = 1'b0, ext_clk_i = 1'b1, rxd_i = 1'b1, cts_ni = 1'b1;
  logic       sclk_a_o, sclk_b_o, txd_o, rts_no;

  always #4 clk = ~clk;

  sync_serial_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i),
    .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o), .rx_done_o(rx_done_o),
    .overrun_o(overrun_o), .int_clk_i(int_clk_i), .div_i(div_i),
    .cont_rx_i(cont_rx_i), .inv_i(inv_i), .dual_clk_i(dual_clk_i),
    .clk_sel_i(clk_sel_i), .hs_en_i(hs_en_i), .ext_clk_i(ext_clk_i),
    .sclk_a_o(sclk_a_o), .sclk_b_o(sclk_b_o), .txd_o(txd_o), .rxd_i(rxd_i),
    .cts_ni(cts_ni), .rts_no(rts_no)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // remote peer: drives rxd on falling clock, collects txd on rising clock
  logic       peer_on = 1'b0;
  logic       peer_clk, txd_d = 1'b1;
  logic [7:0] peer_cur = 8'hFF, peer_got = '0, peer_last = '0;
  logic [7:0] peer_q[$];
  int         pbit = 0;
  int         na = 0, nb = 0;

  assign peer_clk = int_clk_i ? (sclk_a_o & sclk_b_o) : ext_clk_i;

  always @(negedge clk) txd_d <= txd_o;

  always @(negedge peer_clk) if (peer_on) begin
    if (pbit == 0) peer_cur = (peer_q.size() > 0) ? peer_q.pop_front() : 8'hFF;
    rxd_i <= peer_cur[pbit];
  end

  always @(posedge peer_clk) if (peer_on) begin
    peer_got[pbit] = txd_d;
    pbit++;
    if (pbit == 8) begin
      peer_last = peer_got;
      pbit = 0;
    end
  end

  always @(negedge sclk_a_o) if (peer_on) na++;
  always @(negedge sclk_b_o) if (peer_on) nb++;

  // scoreboard
  logic [7:0] exp_rx_q[$], exp_tx_q[$];
  string      tag_q[$];
  logic       mon_en = 1'b1;

  task automatic rd_pulse();
    rx_rd_i = 1'b1;
    @(negedge clk);
    rx_rd_i = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] d);
    @(negedge clk);
    tx_wr_i = 1'b1;
    tx_data_i = d;
    @(negedge clk);
    tx_wr_i = 1'b0;
  endtask

  task automatic expect_xfer(input logic [7:0] host_tx, input logic [7:0] peer_tx,
                             input string tag);
    exp_tx_q.push_back(host_tx);
    exp_rx_q.push_back(inv_i ? ~peer_tx : peer_tx);
    tag_q.push_back(tag);
    peer_q.push_back(peer_tx);
  endtask

  task automatic xfer(input logic [7:0] host, input logic [7:0] peer, input string tag);
    expect_xfer(inv_i ? ~host : host, peer, tag);
    wr_tx(host);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_rx_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "transfer completion", exp_rx_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge rx_done_o);
      if (mon_en) begin
        @(negedge clk);
        if (exp_rx_q.size() == 0) begin
          chk("R3", "unexpected reception", 1, 0);
        end else begin
          string t;
          t = tag_q.pop_front();
          chk(t, "rx_data_o", rx_data_o, exp_rx_q.pop_front());
          chk(t, "peer saw txd", peer_last, exp_tx_q.pop_front());
        end
        rd_pulse();
      end
    end
  end

  task automatic ext_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (8) @(negedge clk);
      ext_clk_i = 1'b0;
      repeat (8) @(negedge clk);
      ext_clk_i = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int a0, b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    peer_on = 1'b1;

    // R1 reset state
    chk("R1", "txd_o", txd_o, 1);
    chk("R1", "sclk_a_o", sclk_a_o, 1);
    chk("R1", "sclk_b_o", sclk_b_o, 1);
    chk("R1", "rts_no", rts_no, 1);
    chk("R1", "rx_done_o", rx_done_o, 0);
    chk("R1", "overrun_o", overrun_o, 0);

    // R3 nothing happens without a transmit write
    repeat (60) @(negedge clk);
    chk("R3", "clock edges while unarmed", na + nb, 0);
    chk("R3", "rx_done_o while unarmed", rx_done_o, 0);

    // R2 / R4 basic frames, pin A by default
    xfer(8'hA5, 8'h3C, "R2");
    drain("R2");
    chk("R2", "falling edges on pin A", na, 8);
    chk("R8", "pin B idle without routing", nb, 0);
    chk("R4", "rx_done_o cleared by read", rx_done_o, 0);
    xfer(8'h00, 8'hFF, "R2");
    drain("R2");
    xfer(8'hFF, 8'h00, "R4");
    drain("R4");
    xfer(8'h81, 8'h7E, "R2");
    drain("R2");

    // R7 inversion at buffer access
    inv_i = 1'b1;
    xfer(8'h96, 8'h35, "R7");
    drain("R7");
    inv_i = 1'b0;

    // R8 clock steering
    a0 = na; b0 = nb;
    dual_clk_i = 1'b1; clk_sel_i = 1'b1;
    xfer(8'h5C, 8'hE1, "R8");
    drain("R8");
    chk("R8", "pin A edges with pin B selected", na, a0);
    chk("R8", "pin B edges with pin B selected", nb, b0 + 8);
    clk_sel_i = 1'b0;
    xfer(8'h2B, 8'hD4, "R8");
    drain("R8");
    chk("R8", "pin A edges with pin A selected", na, a0 + 8);
    chk("R8", "pin B edges with pin A selected", nb, b0 + 8);
    dual_clk_i = 1'b0;

    // R6 continuous receive: read re-arms, second frame sends all ones
    cont_rx_i = 1'b1;
    xfer(8'h5A, 8'h11, "R6");
    expect_xfer(8'hFF, 8'h22, "R6");
    while (exp_rx_q.size() > 1) @(negedge clk);
    repeat (6) @(negedge clk);
    cont_rx_i = 1'b0;
    drain("R6");
    a0 = na;
    repeat (100) @(negedge clk);
    chk("R6", "no frame after read with mode off", na, a0);
    chk("R6", "rx_done_o stays low", rx_done_o, 0);

    // R5 overrun keeps older byte
    mon_en = 1'b0;
    peer_q.push_back(8'h44);
    wr_tx(8'h01);
    repeat (120) @(negedge clk);
    chk("R4", "rx_done_o after frame", rx_done_o, 1);
    peer_q.push_back(8'h55);
    wr_tx(8'h02);
    repeat (120) @(negedge clk);
    chk("R5", "overrun_o", overrun_o, 1);
    chk("R5", "older byte kept", rx_data_o, 8'h44);
    rd_pulse();
    chk("R5", "rx_done_o cleared", rx_done_o, 0);
    chk("R5", "overrun_o cleared", overrun_o, 0);
    mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // R9 external clock, routing selection ignored
    int_clk_i = 1'b0; dual_clk_i = 1'b1; clk_sel_i = 1'b1;
    a0 = na; b0 = nb;
    xfer(8'hC3, 8'h69, "R9");
    ext_clocks(8);
    drain("R9");
    chk("R9", "pin A edges with external clock", na, a0);
    chk("R9", "pin B edges with external clock", nb, b0);
    int_clk_i = 1'b1; dual_clk_i = 1'b0; clk_sel_i = 1'b0;

    // R10 flow control
    hs_en_i = 1'b1; cts_ni = 1'b1;
    a0 = na;
    xfer(8'h12, 8'h34, "R10");
    repeat (40) @(negedge clk);
    chk("R10", "no clock while CTS high", na, a0);
    chk("R10", "rts_no low while armed", rts_no, 0);
    cts_ni = 1'b0;
    drain("R10");
    chk("R10", "rts_no high when idle", rts_no, 1);
    cts_ni = 1'b1;
    dual_clk_i = 1'b1;
    a0 = na;
    xfer(8'h9C, 8'h0F, "R10");
    repeat (10) @(negedge clk);
    chk("R10", "rts_no high with routing on", rts_no, 1);
    drain("R10");
    chk("R10", "frame sent despite CTS high", na, a0 + 8);
    dual_clk_i = 1'b0; hs_en_i = 1'b0;

    summary();
    $finish;
  end
endmodule